// File: doc/BRIEF.md
# I2C Ten-Bit Slave Address Matcher

This block sits behind an I2C slave byte engine and decides, byte by byte, whether the slave is selected when the bus uses ten-bit addressing. The byte engine hands it each received byte with one of two strobes: one for the first byte after a Start or Repeated Start, and one for every later byte. It also reports Start, Repeated Start and Stop conditions. The slave's own ten-bit address comes in as a static input.

A ten-bit address takes two bytes. The first byte carries the fixed prefix `11110`, the top two address bits and the R/W bit. The second byte carries the low eight address bits. A write selects the slave only when both bytes match. A later read sends a Repeated Start and repeats only the first byte with R/W set. Such a read selects the slave only if a full write-mode match came just before it. The block keeps that memory across the Repeated Start. It drives a one-cycle acknowledge request, a selected flag and the transfer direction.

Top module: `i2c_tenbit_match`

## Requirements
- R1: While reset is asserted, and in the first cycle after it, `ack_o`, `sel_o` and `rd_o` are all 0.
- R2: Take a first byte whose bits [7:3] are `11110`, whose bits [2:1] equal `own_addr_i[9:8]`, and whose bit 0 (R/W, 1 = read) is 0. The cycle after its strobe, `ack_o` is 1 and `sel_o` is 0.
- R3: A first byte whose prefix or upper address bits do not match gives `ack_o` = 0 and `sel_o` = 0 the next cycle. It also clears the remembered-addressed state.
- R4: After a matching write first byte, a later byte equal to `own_addr_i[7:0]` gives `ack_o` = 1 and `sel_o` = 1 the next cycle. It also sets the remembered-addressed state.
- R5: After a matching write first byte, a later byte that differs from `own_addr_i[7:0]` gives `ack_o` = 0 and `sel_o` = 0. It also clears the remembered-addressed state.
- R6: While the slave is selected as a receiver, every later data byte is acknowledged and `sel_o` stays 1.
- R7: A matching read first byte that arrives while the remembered state is set gives `ack_o` = 1, `sel_o` = 1 and `rd_o` = 1 the next cycle.
- R8: A matching read first byte that arrives without the remembered state gives `ack_o` = 0 and `sel_o` = 0.
- R9: A Stop sets `sel_o` to 0 the next cycle and clears the remembered state. A following read first byte is then not acknowledged.
- R10: A Start clears the remembered state; a Repeated Start keeps it. Both set `sel_o` to 0 the next cycle.
- R11: `rd_o` follows the R/W bit of the most recent first byte whose prefix and upper bits match, even when that byte is not acknowledged. Other events leave it unchanged.
- R12: `ack_o` is a one-cycle pulse in the cycle after a byte strobe. In a single cycle, Stop wins over Start, Start wins over Repeated Start, and all three win over byte strobes.
- R13: While the slave is selected as a transmitter (read), later bytes are not acknowledged and `sel_o` stays 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start_i | input | 1 | Start condition seen on the bus |
| rstart_i | input | 1 | Repeated Start condition seen on the bus |
| stop_i | input | 1 | Stop condition seen on the bus |
| first_vld_i | input | 1 | `byte_i` is the first byte after a Start or Repeated Start |
| next_vld_i | input | 1 | `byte_i` is a later byte of the frame |
| byte_i | input | 8 | Received byte |
| own_addr_i | input | 10 | The slave's programmed ten-bit address |
| ack_o | output | 1 | Request to acknowledge the byte just received |
| sel_o | output | 1 | Slave is selected |
| rd_o | output | 1 | Transfer direction, 1 = read (slave transmits) |

## Verification
Every result (the acknowledge pulse, the selected flag and the direction) is registered exactly once. Each is therefore due in the cycle right after the clock edge that samples its strobe or bus condition. The bench drives its inputs just after a rising edge and holds them for one cycle. Its behavioural model advances on the same edge, and the bench compares the model with the outputs at the following falling edge, on every clock. On top of that, directed checks read the outputs at that same falling edge after each byte or bus event, so each requirement is confirmed in the cycle it applies to and no earlier.

// File: rtl/i2c_tenbit_pkg.sv
package i2c_tenbit_pkg;

    localparam int BYTE_W = 8;
    localparam int ADDR_W = 10;
    localparam int HI_W   = ADDR_W - BYTE_W;
    localparam int PFX_W  = BYTE_W - HI_W - 1;
    localparam logic [PFX_W-1:0] TEN_PFX = 5'b11110;

    typedef enum logic [2:0] {
        M_IDLE,
        M_WAIT_LO,
        M_RX,
        M_TX,
        M_SKIP
    } mstate_e;

    typedef struct packed {
        mstate_e st;
        logic    mem;
        logic    sel;
        logic    ack;
        logic    rd;
    } match_s;

endpackage

// File: rtl/i2c_tenbit_head.sv
module i2c_tenbit_head
    import i2c_tenbit_pkg::*;
(
    input  logic [BYTE_W-1:0] byte_i,
    input  logic [HI_W-1:0]   own_hi_i,
    output logic              hit_o,
    output logic              rw_o
);
    logic [PFX_W-1:0] pfx_eq;

    genvar g;
    generate
        for (g = 0; g < PFX_W; g++) begin : g_pfx
            assign pfx_eq[g] = (byte_i[BYTE_W-PFX_W+g] == TEN_PFX[g]);
        end
    endgenerate

    always_comb begin
        hit_o = (&pfx_eq) && (byte_i[HI_W:1] == own_hi_i);
        rw_o  = byte_i[0];
    end
endmodule

// File: rtl/i2c_tenbit_low.sv
module i2c_tenbit_low
    import i2c_tenbit_pkg::*;
(
    input  logic [BYTE_W-1:0] byte_i,
    input  logic [BYTE_W-1:0] own_lo_i,
    output logic              eq_o
);
    always_comb begin
        eq_o = (byte_i == own_lo_i);
    end
endmodule

// File: rtl/i2c_tenbit_match.sv
module i2c_tenbit_match
    import i2c_tenbit_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start_i,
    input  logic              rstart_i,
    input  logic              stop_i,
    input  logic              first_vld_i,
    input  logic              next_vld_i,
    input  logic [BYTE_W-1:0] byte_i,
    input  logic [ADDR_W-1:0] own_addr_i,
    output logic              ack_o,
    output logic              sel_o,
    output logic              rd_o
);
    match_s cur_q, nxt_d;
    logic   hd_hit, hd_rw, lo_eq;

    i2c_tenbit_head u_head (
        .byte_i   (byte_i),
        .own_hi_i (own_addr_i[ADDR_W-1:BYTE_W]),
        .hit_o    (hd_hit),
        .rw_o     (hd_rw)
    );

    i2c_tenbit_low u_low (
        .byte_i   (byte_i),
        .own_lo_i (own_addr_i[BYTE_W-1:0]),
        .eq_o     (lo_eq)
    );

    always_comb begin
        nxt_d     = cur_q;
        nxt_d.ack = 1'b0;
        if (stop_i) begin
            nxt_d.st  = M_IDLE;
            nxt_d.mem = 1'b0;
            nxt_d.sel = 1'b0;
        end else if (start_i || rstart_i) begin
            nxt_d.st  = M_IDLE;
            nxt_d.sel = 1'b0;
            if (start_i) nxt_d.mem = 1'b0;
        end else if (first_vld_i) begin
            if (!hd_hit) begin
                nxt_d.st  = M_SKIP;
                nxt_d.sel = 1'b0;
                nxt_d.mem = 1'b0;
            end else begin
                nxt_d.rd = hd_rw;
                if (!hd_rw) begin
                    nxt_d.st  = M_WAIT_LO;
                    nxt_d.sel = 1'b0;
                    nxt_d.mem = 1'b0;
                    nxt_d.ack = 1'b1;
                end else if (cur_q.mem) begin
                    nxt_d.st  = M_TX;
                    nxt_d.sel = 1'b1;
                    nxt_d.ack = 1'b1;
                end else begin
                    nxt_d.st  = M_SKIP;
                    nxt_d.sel = 1'b0;
                end
            end
        end else if (next_vld_i) begin
            unique case (cur_q.st)
                M_WAIT_LO: begin
                    if (lo_eq) begin
                        nxt_d.st  = M_RX;
                        nxt_d.sel = 1'b1;
                        nxt_d.mem = 1'b1;
                        nxt_d.ack = 1'b1;
                    end else begin
                        nxt_d.st  = M_SKIP;
                        nxt_d.sel = 1'b0;
                        nxt_d.mem = 1'b0;
                    end
                end
                M_RX:    nxt_d.ack = 1'b1;
                M_TX:    nxt_d.ack = 1'b0;
                default: nxt_d.ack = 1'b0;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cur_q <= '{st: M_IDLE, mem: 1'b0, sel: 1'b0, ack: 1'b0, rd: 1'b0};
        end else begin
            cur_q <= nxt_d;
        end
    end

    assign ack_o = cur_q.ack;
    assign sel_o = cur_q.sel;
    assign rd_o  = cur_q.rd;

    // R9
    stop_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
        stop_i |=> (!sel_o && !ack_o && !cur_q.mem));

    // R12
    ack_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ack_o |-> $past(first_vld_i || next_vld_i));

    // R8
    rd_nomem_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (first_vld_i && byte_i[0] && !cur_q.mem && !stop_i && !start_i && !rstart_i)
        |=> !sel_o);

    // R4
    sel_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(sel_o) |-> ack_o);

    // R10
    start_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (start_i || rstart_i) |=> !sel_o);

    // R13
    tx_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (sel_o && rd_o && next_vld_i && !first_vld_i && !stop_i && !start_i && !rstart_i)
        |=> (!ack_o && sel_o));
endmodule

// File: tb/sim_i2c_tenbit_match.sv
module sim_i2c_tenbit_match;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       start_i = 0, rstart_i = 0, stop_i = 0;
    logic       first_vld_i = 0, next_vld_i = 0;
    logic [7:0] byte_i = 8'h00;
    logic [9:0] own_addr_i = 10'h2A5;
    logic       ack_o, sel_o, rd_o;

    int total = 0;
    int bad = 0;
    string tag = "R1";

    // reference model state
    int  m_phase = 0;   // 0 idle, 1 want low byte, 2 receiving, 3 sending, 4 ignore
    bit  m_mem = 0;
    bit  e_ack = 0, e_sel = 0, e_rd = 0;

    always #5 clk = ~clk;

    i2c_tenbit_match u0 (
        .clk(clk), .rst_n(rst_n), .start_i(start_i), .rstart_i(rstart_i),
        .stop_i(stop_i), .first_vld_i(first_vld_i), .next_vld_i(next_vld_i),
        .byte_i(byte_i), .own_addr_i(own_addr_i),
        .ack_o(ack_o), .sel_o(sel_o), .rd_o(rd_o)
    );

    always @(posedge clk) begin
        bit head_ok;
        head_ok = (byte_i[7:3] == 5'd30) && (byte_i[2:1] == own_addr_i[9:8]);
        if (!rst_n) begin
            m_phase = 0; m_mem = 0; e_ack = 0; e_sel = 0; e_rd = 0;
        end else begin
            e_ack = 0;
            if (stop_i) begin
                m_phase = 0; m_mem = 0; e_sel = 0;
            end else if (start_i) begin
                m_phase = 0; m_mem = 0; e_sel = 0;
            end else if (rstart_i) begin
                m_phase = 0; e_sel = 0;
            end else if (first_vld_i) begin
                if (head_ok) e_rd = byte_i[0];
                if (head_ok && !byte_i[0]) begin
                    m_phase = 1; m_mem = 0; e_sel = 0; e_ack = 1;
                end else if (head_ok && m_mem) begin
                    m_phase = 3; e_sel = 1; e_ack = 1;
                end else begin
                    m_phase = 4; e_sel = 0;
                    if (!head_ok) m_mem = 0;
                end
            end else if (next_vld_i) begin
                if (m_phase == 1) begin
                    if (byte_i == own_addr_i[7:0]) begin
                        m_phase = 2; m_mem = 1; e_sel = 1; e_ack = 1;
                    end else begin
                        m_phase = 4; m_mem = 0; e_sel = 0;
                    end
                end else if (m_phase == 2) begin
                    e_ack = 1;
                end
            end
        end
    end

    task automatic chk(input string req, input string what, input logic act, input logic exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s %s actual=%0b expected=%0b", req, what, act, exp);
        end
    endtask

    always @(negedge clk) begin
        if (rst_n) begin
            chk(tag, "ack_o", ack_o, e_ack);
            chk(tag, "sel_o", sel_o, e_sel);
            chk(tag, "rd_o", rd_o, e_rd);
        end
    end

    task automatic pulse_first(input logic [7:0] b);
        @(posedge clk); #1; first_vld_i = 1; byte_i = b;
        @(posedge clk); #1; first_vld_i = 0;
        @(negedge clk);
    endtask

    task automatic pulse_next(input logic [7:0] b);
        @(posedge clk); #1; next_vld_i = 1; byte_i = b;
        @(posedge clk); #1; next_vld_i = 0;
        @(negedge clk);
    endtask

    task automatic cond(input int kind);
        @(posedge clk); #1;
        if (kind == 0) start_i = 1; else if (kind == 1) rstart_i = 1; else stop_i = 1;
        @(posedge clk); #1; start_i = 0; rstart_i = 0; stop_i = 0;
        @(negedge clk);
    endtask

    initial begin
        #200000;
        bad++; total++;
        $display("FAIL watchdog expired");
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk);
        chk("R1", "ack_o in reset", ack_o, 1'b0);
        chk("R1", "sel_o in reset", sel_o, 1'b0);
        @(posedge clk); #1; rst_n = 1;
        @(negedge clk);
        chk("R1", "rd_o after reset", rd_o, 1'b0);

        // write first byte F4, low A5, data
        tag = "R2"; cond(0); pulse_first(8'hF4);
        chk("R2", "ack on head", ack_o, 1'b1);
        chk("R2", "not yet selected", sel_o, 1'b0);
        @(negedge clk); chk("R12", "ack single pulse", ack_o, 1'b0);
        tag = "R4"; pulse_next(8'hA5);
        chk("R4", "ack low", ack_o, 1'b1);
        chk("R4", "selected", sel_o, 1'b1);
        tag = "R6"; pulse_next(8'h3C);
        chk("R6", "data ack", ack_o, 1'b1);
        pulse_next(8'h00);
        chk("R6", "still selected", sel_o, 1'b1);

        // repeated start read
        tag = "R10"; cond(1);
        chk("R10", "deselect on rstart", sel_o, 1'b0);
        tag = "R7"; pulse_first(8'hF5);
        chk("R7", "read ack", ack_o, 1'b1);
        chk("R7", "read sel", sel_o, 1'b1);
        chk("R7", "read dir", rd_o, 1'b1);
        tag = "R13"; pulse_next(8'h11);
        chk("R13", "no ack when sending", ack_o, 1'b0);
        chk("R13", "stays selected", sel_o, 1'b1);

        // stop then read: no memory
        tag = "R9"; cond(2);
        chk("R9", "stop deselects", sel_o, 1'b0);
        cond(0); pulse_first(8'hF5);
        chk("R9", "read after stop nack", ack_o, 1'b0);
        chk("R8", "read without memory unselected", sel_o, 1'b0);
        chk("R11", "dir follows nacked read head", rd_o, 1'b1);

        // low byte mismatch
        tag = "R5"; cond(0); pulse_first(8'hF4);
        chk("R11", "dir back to write", rd_o, 1'b0);
        pulse_next(8'hA4);
        chk("R5", "low mismatch nack", ack_o, 1'b0);
        chk("R5", "low mismatch unselected", sel_o, 1'b0);
        cond(1); pulse_first(8'hF5);
        chk("R5", "memory cleared by mismatch", ack_o, 1'b0);

        // head mismatches
        tag = "R3"; cond(0); pulse_first(8'hF4); pulse_next(8'hA5);
        cond(1); pulse_first(8'hF2);
        chk("R3", "upper bits mismatch nack", ack_o, 1'b0);
        chk("R11", "dir kept on mismatch", rd_o, 1'b0);
        cond(1); pulse_first(8'hF5);
        chk("R3", "memory cleared by mismatch", sel_o, 1'b0);
        cond(0); pulse_first(8'h74);
        chk("R3", "prefix mismatch nack", ack_o, 1'b0);

        // plain Start clears memory
        tag = "R10"; cond(0); pulse_first(8'hF4); pulse_next(8'hA5);
        cond(0); pulse_first(8'hF5);
        chk("R10", "start clears memory", ack_o, 1'b0);

        // priority: stop with first strobe
        tag = "R12"; cond(0); pulse_first(8'hF4); pulse_next(8'hA5);
        @(posedge clk); #1; stop_i = 1; first_vld_i = 1; byte_i = 8'hF5;
        @(posedge clk); #1; stop_i = 0; first_vld_i = 0;
        @(negedge clk);
        chk("R12", "stop beats strobe ack", ack_o, 1'b0);
        chk("R12", "stop beats strobe sel", sel_o, 1'b0);
        @(posedge clk); #1; start_i = 1; rstart_i = 1;
        @(posedge clk); #1; start_i = 0; rstart_i = 0;
        pulse_first(8'hF4); pulse_next(8'hA5);
        @(posedge clk); #1; start_i = 1; rstart_i = 1;
        @(posedge clk); #1; start_i = 0; rstart_i = 0;
        pulse_first(8'hF5);
        chk("R12", "start beats rstart", sel_o, 1'b0);

        repeat (4) @(negedge clk);
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule